// File: doc/BRIEF.md
# Core Ready Handshake Generator

This block tells the programmable fabric when the embedded core may be used. It watches three qualifiers: the configuration-done flag, the tri-state-release flag and the active-low global reset. It raises a core-ready level only after all three have stayed high for a fixed number of system clock cycles. Until then, the block keeps the core's fabric-facing signals in a known safe state. It also drives a reset qualifier that the core logic can use directly.

A full reconfiguration of the fabric takes core-ready away again. The block recognises a full reconfiguration when the done flag and the release flag are both low. A partial reconfiguration is signalled on its own input, and during it core-ready stays high. The global reset is synchronised to the system clock before it enters the qualification. The same input also clears the block's own registers asynchronously.

All pins are plain control levels. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The local bus and strobe groups pass through combinationally once core-ready is high.

Top module: `core_ready_gen`

## Requirements
- R1: While `gbl_rst_n` is low, `core_ready` is 0, `core_rst` is 1, every bit of `lbus_out` is 1 and every bit of `strobe_out` is 0.
- R2: `gbl_rst_n` passes through a SYNC_STAGES-deep (default 2) flop chain before it is used as a qualifier. After it rises with `cfg_done` and `io_release` already high, `core_ready` is first seen high after rising edge number SYNC_STAGES + DELAY_CYC (default 8).
- R3: When not ready, `core_ready` rises after DELAY_CYC (default 6) consecutive rising edges at which `cfg_done`, `io_release` and the synchronised reset are all high.
- R4: If any qualifier is low at an edge before the count completes, the count restarts from zero and DELAY_CYC new qualifying edges are needed.
- R5: While ready with `part_cfg` low, an edge at which both `cfg_done` and `io_release` are low clears `core_ready` at that edge.
- R6: While ready, `core_ready` stays high at any edge where `part_cfg` is high, and also whenever only one of `cfg_done` or `io_release` is low.
- R7: `core_rst`, `lbus_hold` and `strb_hold` are each 1 exactly when `core_ready` is 0.
- R8: When `core_ready` is 0, `lbus_out` is all ones and `strobe_out` is all zeros whatever the inputs are. When it is 1, `lbus_out` equals `lbus_in` and `strobe_out` equals `strobe_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| gbl_rst_n | input | 1 | Active-low global reset; asynchronous assert, synchronised release |
| cfg_done | input | 1 | Fabric configuration done |
| io_release | input | 1 | Tri-state release of fabric I/O |
| part_cfg | input | 1 | Partial reconfiguration in progress |
| lbus_in | input | LBUS_W | Local bus outputs from the core |
| strobe_in | input | STRB_W | Active-high strobes from the core |
| core_ready | output | 1 | Core may be used by the fabric |
| core_rst | output | 1 | Core-reset qualifier, high while not ready |
| lbus_hold | output | 1 | Local bus forced-high control |
| strb_hold | output | 1 | Strobe forced-low control |
| lbus_out | output | LBUS_W | Local bus after safe-state forcing |
| strobe_out | output | STRB_W | Strobes after safe-state forcing |

## Verification
The bench builds the block with DELAY_CYC = 6 and SYNC_STAGES = 2, so the full path from reset release to readiness is eight edges. That path is short enough to drive many complete and interrupted counts. It uses LBUS_W = 8 and STRB_W = 5, small enough that changing bus values are forced or passed through every cycle. A behavioural model tracks the synchroniser depth and the qualifying run length as plain integers. It is compared every clock, through directed reconfiguration, partial-reconfiguration and count-interrupt sequences, then through long pseudo-random stretches with occasional reset pulses.

// File: rtl/crg_pkg.sv
package crg_pkg;
  typedef enum logic [1:0] {
    CRG_WAIT  = 2'd0,
    CRG_COUNT = 2'd1,
    CRG_READY = 2'd2
  } crg_state_e;
endpackage

// File: rtl/crg_rst_sync.sv
module crg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe <= '0;
        else         pipe <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe <= '0;
        else         pipe <= {pipe[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign sync_n = pipe[STAGES-1];
endmodule

// File: rtl/crg_ready_fsm.sv
module crg_ready_fsm
  import crg_pkg::*;
#(
  parameter int DELAY_CYC = 6
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_ok,
  input  logic cfg_done,
  input  logic io_release,
  input  logic part_cfg,
  output logic ready
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  crg_state_e state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic qual, full_cfg;

  assign qual     = cfg_done & io_release & rst_ok;
  assign full_cfg = ~cfg_done & ~io_release & ~part_cfg;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    case (state)
      CRG_WAIT: begin
        cnt_nx = '0;
        if (qual) begin
          if (LAST == '0) state_nx = CRG_READY;
          else begin
            state_nx = CRG_COUNT;
            cnt_nx   = CW'(1);
          end
        end
      end
      CRG_COUNT: begin
        if (!qual) begin
          state_nx = CRG_WAIT;
          cnt_nx   = '0;
        end else if (cnt == LAST) begin
          state_nx = CRG_READY;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + CW'(1);
        end
      end
      CRG_READY: begin
        cnt_nx = '0;
        if (full_cfg) state_nx = CRG_WAIT;
      end
      default: begin
        state_nx = CRG_WAIT;
        cnt_nx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= CRG_WAIT;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign ready = (state == CRG_READY);

  // R3: readiness only appears after an edge that saw all qualifiers high
  p_rise_qualified_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ready) |-> $past(cfg_done && io_release && rst_ok));

  // R3: the run counter never passes its final value
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= LAST);

  // R4: an interrupted count starts over
  p_restart_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (!ready && !(cfg_done && io_release && rst_ok)) |=> (cnt == '0 && !ready));

  // R5: full reconfiguration drops readiness
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (ready && !cfg_done && !io_release && !part_cfg) |=> !ready);

  // R6: partial reconfiguration keeps readiness
  p_partial_keep_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (ready && part_cfg) |=> ready);
endmodule

// File: rtl/crg_safe_gate.sv
module crg_safe_gate #(
  parameter int   W         = 8,
  parameter logic FORCE_VAL = 1'b1
) (
  input  logic         hold,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = hold ? FORCE_VAL : din[i];
    end
  endgenerate
endmodule

// File: rtl/core_ready_gen.sv
module core_ready_gen #(
  parameter int DELAY_CYC   = 6,
  parameter int SYNC_STAGES = 2,
  parameter int LBUS_W      = 16,
  parameter int STRB_W      = 5
) (
  input  logic              clk,
  input  logic              gbl_rst_n,
  input  logic              cfg_done,
  input  logic              io_release,
  input  logic              part_cfg,
  input  logic [LBUS_W-1:0] lbus_in,
  input  logic [STRB_W-1:0] strobe_in,
  output logic              core_ready,
  output logic              core_rst,
  output logic              lbus_hold,
  output logic              strb_hold,
  output logic [LBUS_W-1:0] lbus_out,
  output logic [STRB_W-1:0] strobe_out
);
  logic rst_ok;
  logic ready;
  logic not_ready;

  crg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (gbl_rst_n),
    .sync_n (rst_ok)
  );

  crg_ready_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
    .clk        (clk),
    .arst_n     (gbl_rst_n),
    .rst_ok     (rst_ok),
    .cfg_done   (cfg_done),
    .io_release (io_release),
    .part_cfg   (part_cfg),
    .ready      (ready)
  );

  assign not_ready  = ~ready;
  assign core_ready = ready;
  assign core_rst   = not_ready;
  assign lbus_hold  = not_ready;
  assign strb_hold  = not_ready;

  crg_safe_gate #(.W(LBUS_W), .FORCE_VAL(1'b1)) u_lbus_gate (
    .hold (lbus_hold),
    .din  (lbus_in),
    .dout (lbus_out)
  );

  crg_safe_gate #(.W(STRB_W), .FORCE_VAL(1'b0)) u_strb_gate (
    .hold (strb_hold),
    .din  (strobe_in),
    .dout (strobe_out)
  );

  // R8: safe state on the outputs whenever the core is not ready
  p_safe_outputs_r8: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    !core_ready |-> ((&lbus_out) && !(|strobe_out)));

  // R8: pass-through once ready
  p_pass_through_r8: assert property (@(posedge clk) disable iff (!gbl_rst_n)
    core_ready |-> (lbus_out == lbus_in && strobe_out == strobe_in));
endmodule

// File: tb/core_ready_gen_bench.sv
module core_ready_gen_bench;
  localparam int DLY = 6;
  localparam int SYN = 2;
  localparam int LW  = 8;
  localparam int SW  = 5;

  logic clk = 1'b0;
  logic gbl_rst_n = 1'b0;
  logic cfg_done = 1'b0, io_release = 1'b0, part_cfg = 1'b0;
  logic [LW-1:0] lbus_in = '0;
  logic [SW-1:0] strobe_in = '0;
  logic core_ready, core_rst, lbus_hold, strb_hold;
  logic [LW-1:0] lbus_out;
  logic [SW-1:0] strobe_out;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_sync_age = 0;
  int m_run = 0;
  bit m_rdy = 0;

  always #5 clk = ~clk;

  core_ready_gen #(.DELAY_CYC(DLY), .SYNC_STAGES(SYN), .LBUS_W(LW), .STRB_W(SW)) u_core_ready_gen (
    .clk(clk), .gbl_rst_n(gbl_rst_n), .cfg_done(cfg_done), .io_release(io_release),
    .part_cfg(part_cfg), .lbus_in(lbus_in), .strobe_in(strobe_in),
    .core_ready(core_ready), .core_rst(core_rst), .lbus_hold(lbus_hold),
    .strb_hold(strb_hold), .lbus_out(lbus_out), .strobe_out(strobe_out)
  );

  always @(posedge clk or negedge gbl_rst_n) begin
    if (!gbl_rst_n) begin
      m_sync_age = 0;
      m_run = 0;
      m_rdy = 0;
    end else begin
      bit q;
      q = cfg_done && io_release && (m_sync_age >= SYN);
      if (m_rdy) begin
        if (!part_cfg && !cfg_done && !io_release) begin
          m_rdy = 0;
          m_run = 0;
        end
      end else if (q) begin
        m_run = m_run + 1;
        if (m_run >= DLY) begin
          m_rdy = 1;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
      if (m_sync_age < SYN) m_sync_age = m_sync_age + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #3;
    begin
      logic [LW-1:0] e_l;
      logic [SW-1:0] e_s;
      e_l = m_rdy ? lbus_in : {LW{1'b1}};
      e_s = m_rdy ? strobe_in : {SW{1'b0}};
      check(core_ready == m_rdy, cur_req, "core_ready", 32'(core_ready), 32'(m_rdy));
      check(core_rst == !m_rdy && lbus_hold == !m_rdy && strb_hold == !m_rdy, "R7",
            "core_rst/holds", {29'd0, core_rst, lbus_hold, strb_hold}, {29'd0, {3{!m_rdy}}});
      check(lbus_out == e_l && strobe_out == e_s, "R8", "bus out",
            {11'd0, strobe_out, 8'd0, lbus_out}, {11'd0, e_s, 8'd0, e_l});
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_500_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lbus_in = lbus_in + 8'h35;
      strobe_in = strobe_in ^ 5'h13;
    end
  endtask

  logic [15:0] lf = 16'hACE1;

  initial begin
    int n;
    // R1: reset state
    cur_req = "R1";
    lbus_in = 8'h5A;
    strobe_in = 5'h1F;
    step(4);
    check(core_ready == 0 && core_rst == 1 && lbus_out == 8'hFF && strobe_out == 5'h00,
          "R1", "reset state", {23'd0, core_ready, lbus_out}, {23'd0, 1'b0, 8'hFF});

    // R2/R3: release with qualifiers high, expect first ready after edge SYN+DLY
    cur_req = "R2";
    cfg_done = 1;
    io_release = 1;
    step(2);
    @(negedge clk);
    gbl_rst_n = 1;
    n = 0;
    for (int k = 1; k <= 14; k++) begin
      @(posedge clk);
      #3;
      if (core_ready && n == 0) n = k;
    end
    check(n == SYN + DLY, "R2", "edges to ready", 32'(n), 32'(SYN + DLY));

    // R5: full reconfiguration drops readiness
    cur_req = "R5";
    @(negedge clk);
    cfg_done = 0;
    io_release = 0;
    @(posedge clk);
    #3;
    check(core_ready == 0, "R5", "drop on full reconfig", 32'(core_ready), 0);

    // R4: interrupted count restarts
    cur_req = "R4";
    step(2);
    cfg_done = 1;
    step(3);
    io_release = 1;
    step(4);
    cfg_done = 0;
    step(1);
    cfg_done = 1;
    n = 0;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk);
      #3;
      if (core_ready && n == 0) n = k;
    end
    check(n == DLY, "R4", "edges after restart", 32'(n), 32'(DLY));

    // R3: count of exactly DLY edges from qualification
    cur_req = "R3";
    @(negedge clk);
    cfg_done = 0;
    io_release = 0;
    step(3);
    cfg_done = 1;
    io_release = 1;
    n = 0;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk);
      #3;
      if (core_ready && n == 0) n = k;
    end
    check(n == DLY, "R3", "qualify delay", 32'(n), 32'(DLY));

    // R6: single flag low or partial reconfig keeps readiness
    cur_req = "R6";
    @(negedge clk);
    cfg_done = 0;
    step(3);
    check(core_ready == 1, "R6", "done low only", 32'(core_ready), 1);
    cfg_done = 1;
    io_release = 0;
    step(3);
    check(core_ready == 1, "R6", "release low only", 32'(core_ready), 1);
    part_cfg = 1;
    cfg_done = 0;
    step(5);
    check(core_ready == 1, "R6", "partial reconfig", 32'(core_ready), 1);
    part_cfg = 0;
    step(1);
    @(posedge clk);
    #3;
    check(core_ready == 0, "R5", "drop after partial ends", 32'(core_ready), 0);

    // pseudo-random stretches
    cur_req = "R3";
    for (int blk = 0; blk < 300; blk++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cfg_done   = (lf[2:0] != 3'd0);
      io_release = (lf[5:3] != 3'd0);
      part_cfg   = lf[6] & lf[7];
      gbl_rst_n  = (lf[15:10] != 6'd0);
      step(1 + int'(lf[9:8]) * 3);
    end
    @(negedge clk);
    summary();
    $finish;
  end
endmodule